// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two IEEE binary32 operands and returns their binary32 product. It accepts one operand pair on any clock where the input strobe is high. The result appears with its own strobe a fixed two clocks later. A new pair may be offered on every clock.

The arithmetic is one combinational wave. It sits between a single rank of operand registers and a single rank of result registers, and nothing is registered inside the datapath. The wave XORs the signs, sums the biased exponents and takes the bias away once, and forms the 48-bit significand product. It then normalizes, rounds to nearest with ties to even, and finally applies saturation and special-value rules.

Normal numbers, zeros, infinities and NaNs are handled. Subnormal operands are read as zero, and results too small to be normal are flushed to zero.

Top module: `fmul32`

## Requirements
- R1: For every finite or infinite result that is not NaN, bit 31 of `product` equals the XOR of bit 31 of the two operands.
- R2: For two normal operands, the significands with hidden one are multiplied. If bit 47 of the 48-bit product is set, the product is shifted right by one and the exponent rises by one. The biased result exponent is the sum of the operand exponents (bits 30:23) less 127.
- R3: The 23-bit fraction is rounded to nearest from a guard bit and a sticky bit. An exact tie rounds to the even fraction.
- R4: When rounding carries out of the 24-bit significand, the result is renormalized and the exponent rises by one more.
- R5: A final biased exponent of 255 or more yields infinity with the result sign (exponent field all ones, fraction zero).
- R6: A final biased exponent of 0 or less yields a signed zero. Any operand whose exponent field is 0 counts as zero whatever its fraction.
- R7: An operand with exponent field 255 and a nonzero fraction, or zero times infinity, yields exactly 0x7FC00000.
- R8: Infinity times a nonzero non-NaN value yields signed infinity. Zero times a finite value yields signed zero.
- R9: `out_valid` is high in the clock two edges after the edge that sampled `in_valid` high, and only then. Pairs on consecutive clocks each produce a result.
- R10: A synchronous reset clears `out_valid` and `product` to zero and drops any operand pair in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair strobe |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result strobe |
| product | output | 32 | Binary32 product |

## Verification
The bench targets the two normalization branches, exact ties on both odd and even fractions, and a pair whose significand product rounds up past 2.0. A design that mishandled any of these would be off by one unit in the last place or by a factor of two. It drives exponent sums just above, at and below the saturation limits. A wrong bound would let a finite value wrap to a small number or leak a stray denormal pattern. It also covers NaN propagation, zero times infinity and subnormal inputs, where a wrong priority returns infinity or a raw fraction instead of the canonical NaN or zero. Back-to-back traffic with gaps, and a reset in mid-stream, catch any strobe that slips a cycle or any pair that survives a reset.

// File: rtl/fmul32.sv
module fmul32 #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     product
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int SIG_W = FRAC_W + 1;
  localparam int PRD_W = 2 * SIG_W;
  localparam int EXT_W = EXP_W + 2;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX  = (1 << EXP_W) - 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic         v_q;
  logic [W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= in_valid;
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  wire              sgn = a_q[W-1] ^ b_q[W-1];
  wire [EXP_W-1:0]  ea  = a_q[W-2:FRAC_W];
  wire [EXP_W-1:0]  eb  = b_q[W-2:FRAC_W];
  wire [FRAC_W-1:0] fa  = a_q[FRAC_W-1:0];
  wire [FRAC_W-1:0] fb  = b_q[FRAC_W-1:0];

  wire a_zero = (ea == '0);
  wire b_zero = (eb == '0);
  wire a_top  = (ea == {EXP_W{1'b1}});
  wire b_top  = (eb == {EXP_W{1'b1}});
  wire a_nan  = a_top && (fa != '0);
  wire b_nan  = b_top && (fb != '0);
  wire a_inf  = a_top && (fa == '0);
  wire b_inf  = b_top && (fb == '0);

  wire [PRD_W-1:0] prod = {1'b1, fa} * {1'b1, fb};
  wire             hi   = prod[PRD_W-1];

  logic [SIG_W-1:0] sig;
  logic             guard, sticky;
  always_comb begin
    if (hi) begin
      sig    = prod[PRD_W-1 -: SIG_W];
      guard  = prod[PRD_W-1-SIG_W];
      sticky = |prod[PRD_W-2-SIG_W:0];
    end else begin
      sig    = prod[PRD_W-2 -: SIG_W];
      guard  = prod[PRD_W-2-SIG_W];
      sticky = |prod[PRD_W-3-SIG_W:0];
    end
  end

  wire             rnd   = guard && (sticky || sig[0]);
  wire [SIG_W:0]   sig_r = {1'b0, sig} + {{SIG_W{1'b0}}, rnd};
  wire             carry = sig_r[SIG_W];

  wire signed [EXT_W-1:0] e_fin = $signed({2'b00, ea}) + $signed({2'b00, eb})
                                  - EXT_W'(BIAS)
                                  + $signed({{(EXT_W-1){1'b0}}, hi})
                                  + $signed({{(EXT_W-1){1'b0}}, carry});

  wire [FRAC_W-1:0] frac_n = carry ? '0 : sig_r[FRAC_W-1:0];

  logic [W-1:0] res_c;
  always_comb begin
    if (a_nan || b_nan || (a_zero && b_inf) || (b_zero && a_inf))
      res_c = QNAN;
    else if (a_inf || b_inf)
      res_c = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (a_zero || b_zero)
      res_c = {sgn, {(W-1){1'b0}}};
    else if (e_fin >= $signed(EXT_W'(EMAX)))
      res_c = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (e_fin <= $signed(EXT_W'(0)))
      res_c = {sgn, {(W-1){1'b0}}};
    else
      res_c = {sgn, e_fin[EXP_W-1:0], frac_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= v_q;
      product   <= res_c;
    end
  end

  // R9
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> out_valid);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst, 1) && !$past(rst, 2)) |-> $past(in_valid, 2));
  // R10
  reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && product == '0));
  // R7
  nan_chk: assert property (@(posedge clk) disable iff (rst)
    (v_q && (a_nan || b_nan)) |=> (product == QNAN));
  // R1
  sign_chk: assert property (@(posedge clk) disable iff (rst)
    v_q |=> (product == QNAN || product[W-1] == $past(a_q[W-1] ^ b_q[W-1])));
  // R8
  inf_chk: assert property (@(posedge clk) disable iff (rst)
    (v_q && a_inf && !b_zero && !b_nan) |=> (product[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R6
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    (v_q && a_zero && !b_top) |=> (product[W-2:0] == '0));
endmodule

// File: tb/sim_fmul32.sv
module sim_fmul32;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [31:0] product;

  always #2 clk = ~clk;

  fmul32 u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
             .out_valid(out_valid), .product(product));

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string cur_tag = "R2";
  logic        ev1 = 0, ev2 = 0;
  logic [31:0] er1 = '0, er2 = '0;
  string       t1 = "", t2 = "";

  function automatic logic [31:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
    int ex, ey, e, sh;
    longint mx, my, p, keep, rem, half;
    logic s;
    bit xn, yn, xi, yi, xz, yz;
    s  = x[31] ^ y[31];
    ex = int'(x[30:23]);
    ey = int'(y[30:23]);
    xn = (ex == 255) && (x[22:0] != 0);
    yn = (ey == 255) && (y[22:0] != 0);
    xi = (ex == 255) && (x[22:0] == 0);
    yi = (ey == 255) && (y[22:0] == 0);
    xz = (ex == 0);
    yz = (ey == 0);
    if (xn || yn || (xz && yi) || (yz && xi)) return 32'h7FC00000;
    if (xi || yi) return {s, 8'hFF, 23'h0};
    if (xz || yz) return {s, 31'h0};
    mx = longint'(x[22:0]) + (longint'(1) << 23);
    my = longint'(y[22:0]) + (longint'(1) << 23);
    p  = mx * my;
    sh = (p >= (longint'(1) << 47)) ? 24 : 23;
    e  = ex + ey - 127 + (sh - 23);
    keep = p >> sh;
    rem  = p - (keep << sh);
    half = longint'(1) << (sh - 1);
    if (rem > half || (rem == half && (keep % 2) == 1)) keep = keep + 1;
    if (keep == (longint'(1) << 24)) begin
      keep = keep >> 1;
      e = e + 1;
    end
    if (e >= 255) return {s, 8'hFF, 23'h0};
    if (e <= 0) return {s, 31'h0};
    return {s, 8'(e), 23'(keep)};
  endfunction

  always @(posedge clk) begin
    ev1 <= rst ? 1'b0 : in_valid;
    ev2 <= rst ? 1'b0 : ev1;
    er1 <= ref_mul(op_a, op_b);
    er2 <= er1;
    t1  <= cur_tag;
    t2  <= t1;
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (out_valid !== ev2) begin
        n_bad++;
        $display("FAIL R9 out_valid actual=%b expected=%b at %0t", out_valid, ev2, $time);
      end
      if (ev2) begin
        n_cmp++;
        if (product !== er2) begin
          n_bad++;
          $display("FAIL %s product actual=%h expected=%h at %0t", t2, product, er2, $time);
        end
      end
    end
  end

  task automatic send(input logic [31:0] x, input logic [31:0] y, input string t);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = x;
    op_b = y;
    cur_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 32'hDEADBEEF;
      op_b = 32'h3F800000;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r, x, y;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || product !== 32'h0) begin
      n_bad++;
      $display("FAIL R10 reset state actual=%b/%h expected=0/00000000", out_valid, product);
    end
    rst = 1'b0;
    idle(2);
    send(32'h3FC00000, 32'h3FC00000, "R2");
    send(32'h40000000, 32'h40400000, "R2");
    send(32'hC0000000, 32'h40400000, "R1");
    send(32'hBF800000, 32'hBFC00000, "R1");
    send(32'h3F800001, 32'h3FC00000, "R3");
    send(32'h3F800003, 32'h3FC00000, "R3");
    send(32'h3F800001, 32'h3F800001, "R3");
    send(32'h3FFFFFFE, 32'h3F800001, "R4");
    send(32'h7F000000, 32'h40000000, "R5");
    send(32'h7F000000, 32'h3F800000, "R5");
    send(32'h7F7FFFFF, 32'h3F800001, "R5");
    send(32'hFF000000, 32'h7F000000, "R5");
    send(32'h00800000, 32'h3F000000, "R6");
    send(32'h00800000, 32'h3F800000, "R6");
    send(32'h00000001, 32'h3F800000, "R6");
    send(32'h807FFFFF, 32'h7F000000, "R6");
    send(32'h7FC00001, 32'h3F800000, "R7");
    send(32'h3F800000, 32'hFF800001, "R7");
    send(32'h00000000, 32'hFF800000, "R7");
    send(32'h7F800000, 32'h00400000, "R7");
    send(32'h7F800000, 32'hC0000000, "R8");
    send(32'hFF800000, 32'hFF800000, "R8");
    send(32'h80000000, 32'h40490FDB, "R8");
    idle(1);
    send(32'h3F800000, 32'h40000000, "R9");
    idle(2);
    send(32'h40400000, 32'h40400000, "R9");
    send(32'h40800000, 32'h3E800000, "R9");
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || product !== 32'h0) begin
      n_bad++;
      $display("FAIL R10 mid-stream reset actual=%b/%h expected=0/00000000", out_valid, product);
    end
    rst = 1'b0;
    r = 32'h1234ABCD;
    for (int k = 0; k < 3000; k++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      x = {r[31], 8'(96 + r[30:25]), r[22:0]};
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      y = (r[3:0] == 4'h0) ? r : {r[31], 8'(96 + r[30:25]), r[22:0]};
      if (r[7:5] == 3'b000) idle(1);
      send(x, y, "R2");
    end
    idle(4);
    finish_run();
  end
endmodule